// File: doc/BRIEF.md
# Dual-Vector Handshake Interrupt Controller

This block is the host-facing control and status logic of a communications coprocessor. The host and the device pass commands to each other through two ready flags in a 16-bit control register that is read and written one byte at a time. An input-ready flag tells the host that the device will accept a command. An output-ready flag tells the host that the device has posted a result. Each flag is signalled through its own interrupt vector. Input-ready always uses the base vector A, and output-ready always uses vector B, which sits 4 above A.

The host asks for a command slot by setting a request-input bit. The device answers by raising input-ready. Once the host clears input-ready after loading a command, the device keeps input-ready down until its engine reports that the command has been consumed. This prevents an immediate second vector A interrupt while the host still has commands queued. When the host acknowledges, the block returns in the same cycle the address of the vector that won arbitration, and vector A wins when both are pending. A request goes away in the cycle after the host clears its ready flag. The high byte also holds a run bit and two maintenance controls, a maintenance mode bit and a single-step bit, which drive the engine.

Top module: `dual_vec_irq`

## Requirements
- R1: After a synchronous reset both register bytes read 0x00, `irq_req` is low, and an acknowledge returns no valid vector.
- R2: Low byte layout: bit 0 is the A enable, bit 1 the B enable, bit 4 input-ready, bit 5 request-input, bit 7 output-ready. High byte layout: bit 0 single-step, bit 1 maintenance, bit 7 run. All other bits read 0, and a plain write (op 0) loads the writable bits of the selected byte.
- R3: Op 1 sets the bits that are 1 in the write data. Op 2 clears the bits that are 1 in the write data. Op 3 changes nothing.
- R4: The host cannot set either ready flag. A plain write with that bit 0, or op 2 with that bit 1, clears the flag.
- R5: While run and request-input are both 1, input-ready is clear and the hold-off below is inactive, the device sets input-ready on the next clock edge.
- R6: When the host clears input-ready, a hold-off starts that keeps input-ready clear until a `dev_cmd_done` pulse. After the pulse, R5 applies again.
- R7: A `dev_out_post` pulse sets output-ready. If the host clears output-ready in the same cycle, the set wins.
- R8: Vector A is pending when input-ready, the A enable and run are all 1. Vector B is pending when output-ready, the B enable and run are all 1. `irq_req` is the OR of the two, and it drops after the clock edge that clears the flag.
- R9: When `irq_ack` is high, `irq_vec_valid` shows whether a request is pending. `irq_vec` is VBASE if A is pending, including when both are pending, and VBASE+4 if only B is pending.
- R10: While run is clear, no vector is requested, but the ready flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write strobe |
| host_op | input | 2 | 0 write, 1 bit-set, 2 bit-clear, 3 no-op |
| host_byte | input | 1 | Byte select for writes (0 low, 1 high) |
| host_wdata | input | 8 | Write data |
| host_rbyte | input | 1 | Byte select for reads |
| host_rdata | output | 8 | Read data of the selected byte |
| dev_cmd_done | input | 1 | Engine has consumed the last command |
| dev_out_post | input | 1 | Engine posts an output result |
| irq_ack | input | 1 | Interrupt acknowledge from host |
| irq_req | output | 1 | Interrupt request |
| irq_vec_valid | output | 1 | Acknowledge returned a vector |
| irq_vec | output | VW | Granted vector address |
| eng_run | output | 1 | Run control to engine |
| eng_maint | output | 1 | Maintenance mode control |
| eng_step | output | 1 | Single-step control |

## Verification
On every cycle the assertions check that requests are masked by run, that a request only exists while a ready flag is up, and that a granted vector respects A-over-B priority. They also check that the hold-off keeps input-ready low, that a pending request-input is answered on the next edge, and that a device post always lands. Only the bench scenarios can show the full command exchange in order: the register byte layout, the effect of each write op, the release of the hold-off by the engine, and which side wins when a set and a clear collide.

// File: rtl/dual_vec_irq.sv
module dual_vec_irq #(
  parameter int VW = 9,
  parameter logic [VW-1:0] VBASE = 9'o300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_op,
  input  logic          host_byte,
  input  logic [7:0]    host_wdata,
  input  logic          host_rbyte,
  output logic [7:0]    host_rdata,
  input  logic          dev_cmd_done,
  input  logic          dev_out_post,
  input  logic          irq_ack,
  output logic          irq_req,
  output logic          irq_vec_valid,
  output logic [VW-1:0] irq_vec,
  output logic          eng_run,
  output logic          eng_maint,
  output logic          eng_step
);
  localparam logic [1:0] OP_WR = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2;
  localparam logic [VW-1:0] VSTEP = VW'(4);

  logic ien_a, ien_b, rqi, in_rdy, out_rdy, hold;
  logic run, maint, step;
  logic wr_lo, wr_hi, host_clr_in, host_clr_out, dev_set_in;
  logic pend_a, pend_b;

  function automatic logic upd(input logic cur, input logic bitv, input logic [1:0] op);
    case (op)
      OP_WR:   upd = bitv;
      OP_SET:  upd = cur | bitv;
      OP_CLR:  upd = cur & ~bitv;
      default: upd = cur;
    endcase
  endfunction

  assign wr_lo = host_we && !host_byte;
  assign wr_hi = host_we && host_byte;
  assign host_clr_in  = wr_lo && ((host_op == OP_WR && !host_wdata[4]) ||
                                  (host_op == OP_CLR && host_wdata[4]));
  assign host_clr_out = wr_lo && ((host_op == OP_WR && !host_wdata[7]) ||
                                  (host_op == OP_CLR && host_wdata[7]));
  assign dev_set_in = run && rqi && !hold && !in_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_a <= 1'b0; ien_b <= 1'b0; rqi <= 1'b0;
      in_rdy <= 1'b0; out_rdy <= 1'b0; hold <= 1'b0;
      run <= 1'b0; maint <= 1'b0; step <= 1'b0;
    end else begin
      if (wr_lo) begin
        ien_a <= upd(ien_a, host_wdata[0], host_op);
        ien_b <= upd(ien_b, host_wdata[1], host_op);
        rqi   <= upd(rqi,   host_wdata[5], host_op);
      end
      if (wr_hi) begin
        step  <= upd(step,  host_wdata[0], host_op);
        maint <= upd(maint, host_wdata[1], host_op);
        run   <= upd(run,   host_wdata[7], host_op);
      end
      if (host_clr_in) in_rdy <= 1'b0;
      else if (dev_set_in) in_rdy <= 1'b1;
      if (host_clr_in && in_rdy) hold <= 1'b1;
      else if (dev_cmd_done) hold <= 1'b0;
      if (dev_out_post) out_rdy <= 1'b1;
      else if (host_clr_out) out_rdy <= 1'b0;
    end
  end

  assign pend_a = run && ien_a && in_rdy;
  assign pend_b = run && ien_b && out_rdy;
  assign irq_req = pend_a || pend_b;
  assign irq_vec_valid = irq_ack && irq_req;
  assign irq_vec = !irq_vec_valid ? '0 : (pend_a ? VBASE : VBASE + VSTEP);

  assign host_rdata = host_rbyte ? {run, 5'b0, maint, step}
                                 : {out_rdy, 1'b0, rqi, in_rdy, 2'b0, ien_b, ien_a};
  assign eng_run = run;
  assign eng_maint = maint;
  assign eng_step = step;
endmodule

// File: rtl/dual_vec_irq_chk.sv
module dual_vec_irq_chk #(
  parameter int VW = 9,
  parameter logic [VW-1:0] VBASE = 9'o300
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          ien_a,
  input logic          rqi,
  input logic          in_rdy,
  input logic          out_rdy,
  input logic          hold,
  input logic          host_clr_in,
  input logic          dev_out_post,
  input logic          irq_ack,
  input logic          irq_req,
  input logic          irq_vec_valid,
  input logic [VW-1:0] irq_vec
);
  a_r10_run_masks: assert property (@(posedge clk) disable iff (rst) !run |-> !irq_req);
  a_r8_needs_flag: assert property (@(posedge clk) disable iff (rst) (!in_rdy && !out_rdy) |-> !irq_req);
  a_r9_a_first: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && run && ien_a && in_rdy) |-> (irq_vec_valid && irq_vec == VBASE));
  a_r9_valid_pend: assert property (@(posedge clk) disable iff (rst) irq_vec_valid |-> irq_req);
  a_r6_holdoff: assert property (@(posedge clk) disable iff (rst) hold |-> !in_rdy);
  a_r5_answer: assert property (@(posedge clk) disable iff (rst)
    (run && rqi && !hold && !in_rdy && !host_clr_in) |=> in_rdy);
  a_r7_post_lands: assert property (@(posedge clk) disable iff (rst) dev_out_post |=> out_rdy);
endmodule

bind dual_vec_irq dual_vec_irq_chk #(.VW(VW), .VBASE(VBASE)) u_chk (
  .clk(clk), .rst(rst), .run(run), .ien_a(ien_a), .rqi(rqi), .in_rdy(in_rdy),
  .out_rdy(out_rdy), .hold(hold), .host_clr_in(host_clr_in),
  .dev_out_post(dev_out_post), .irq_ack(irq_ack), .irq_req(irq_req),
  .irq_vec_valid(irq_vec_valid), .irq_vec(irq_vec)
);

// File: tb/dual_vec_irq_test.sv
module dual_vec_irq_test;
  localparam logic [8:0] VA = 9'o300;
  localparam logic [8:0] VB = 9'o304;

  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 0, host_byte = 0, host_rbyte = 0;
  logic [1:0] host_op = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic dev_cmd_done = 0, dev_out_post = 0, irq_ack = 0;
  logic irq_req, irq_vec_valid, eng_run, eng_maint, eng_step;
  logic [8:0] irq_vec;
  int total = 0, bad = 0;
  logic done = 0;

  always #10 clk = ~clk;

  dual_vec_irq uut (.*);

  // {byte, op, data, expected readback}
  localparam logic [18:0] TBL [12] = '{
    {1'b0, 2'd0, 8'hFF, 8'h23}, {1'b0, 2'd2, 8'h01, 8'h22},
    {1'b0, 2'd1, 8'h01, 8'h23}, {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b0, 2'd3, 8'hFF, 8'h00}, {1'b1, 2'd0, 8'hFF, 8'h83},
    {1'b1, 2'd2, 8'h80, 8'h03}, {1'b1, 2'd2, 8'h01, 8'h02},
    {1'b1, 2'd1, 8'h01, 8'h03}, {1'b1, 2'd0, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'h20, 8'h20}, {1'b0, 2'd2, 8'h20, 8'h00}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_byte = b; host_op = op; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input logic b, output logic [7:0] d);
    host_rbyte = b; #1; d = host_rdata;
  endtask

  task automatic ack(output logic v, output logic [8:0] vec);
    irq_ack = 1; #1; v = irq_vec_valid; vec = irq_vec; irq_ack = 0;
  endtask

  task automatic pulse_post();
    @(negedge clk); dev_out_post = 1; @(negedge clk); dev_out_post = 0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic v;
    logic [8:0] vec;
    repeat (2) @(negedge clk);
    rst = 0;
    rd(0, r); chk("R1 low", {8'h0, r}, 16'h0);
    rd(1, r); chk("R1 high", {8'h0, r}, 16'h0);
    ack(v, vec); chk("R1 irq/ack", {14'h0, irq_req, v}, 16'h0);

    for (int i = 0; i < 12; i++) begin
      wr(TBL[i][18], TBL[i][17:16], TBL[i][15:8]);
      rd(TBL[i][18], r);
      chk(i < 5 ? "R2/R3/R4 low table" : "R2/R3 high table", {8'h0, r}, {8'h0, TBL[i][7:0]});
    end
    chk("R2 engine pins", {13'h0, eng_run, eng_maint, eng_step}, 16'h0);
    wr(1, 2'd1, 8'h03);
    chk("R2 maint/step pins", {13'h0, eng_run, eng_maint, eng_step}, 16'h3);
    wr(1, 2'd0, 8'h00);

    wr(0, 2'd0, 8'h03);
    wr(1, 2'd1, 8'h80);
    wr(0, 2'd1, 8'h20);
    rd(0, r); chk("R5 not yet", {8'h0, r}, 16'h23);
    @(negedge clk);
    rd(0, r); chk("R5 input-ready answered", {8'h0, r}, 16'h33);
    chk("R8 irq on A", {15'h0, irq_req}, 16'h1);
    ack(v, vec); chk("R9 vector A", {6'h0, v, vec}, {6'h0, 1'b1, VA});

    pulse_post();
    rd(0, r); chk("R7 output-ready", {8'h0, r}, 16'hB3);
    ack(v, vec); chk("R9 A over B", {6'h0, v, vec}, {6'h0, 1'b1, VA});

    wr(0, 2'd2, 8'h10);
    repeat (3) @(negedge clk);
    rd(0, r); chk("R6 held clear", {8'h0, r}, 16'hA3);
    ack(v, vec); chk("R9 vector B alone", {6'h0, v, vec}, {6'h0, 1'b1, VB});

    @(negedge clk); dev_cmd_done = 1; @(negedge clk); dev_cmd_done = 0;
    @(negedge clk);
    rd(0, r); chk("R6 released", {8'h0, r}, 16'hB3);

    wr(1, 2'd2, 8'h80);
    ack(v, vec); chk("R10 run masks", {14'h0, irq_req, v}, 16'h0);
    rd(0, r); chk("R10 flags kept", {8'h0, r}, 16'hB3);

    wr(1, 2'd1, 8'h80);
    wr(0, 2'd2, 8'h01);
    ack(v, vec); chk("R8 A disabled", {6'h0, v, vec}, {6'h0, 1'b1, VB});

    wr(0, 2'd0, 8'h22);
    rd(0, r); chk("R4 plain write clears", {8'h0, r}, 16'h22);
    chk("R8 withdrawn", {15'h0, irq_req}, 16'h0);

    @(negedge clk);
    host_we = 1; host_byte = 0; host_op = 2'd2; host_wdata = 8'h80; dev_out_post = 1;
    @(negedge clk);
    host_we = 0; dev_out_post = 0;
    rd(0, r); chk("R7 set wins", {8'h0, r}, 16'hA2);

    wr(0, 2'd1, 8'h10);
    rd(0, r); chk("R4 host cannot set", {8'h0, r}, 16'hA2);

    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rd(0, r); chk("R1 re-reset low", {8'h0, r}, 16'h0);
    rd(1, r); chk("R1 re-reset high", {8'h0, r}, 16'h0);
    chk("R1 re-reset irq", {15'h0, irq_req}, 16'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule